// File: doc/BRIEF.md
# Addressed Asynchronous Serial Receiver

This block receives asynchronous serial frames that carry 8 or 9 data bits. It samples the line at sixteen times the bit rate and decides each bit by a majority vote. A frame is delivered to the host as a data byte, a ninth bit and a receive-done flag. In multiprocessor operation the block compares each incoming address frame against two patterns: the node's own address and a broadcast pattern. Only frames that match raise the flag, so the host never services traffic meant for other nodes. A sticky framing-error flag records stop bits that were received low.

The host sets the frame length, the multiprocessor enable and the framing-check enable. It also supplies an address register and a mask. It clears each flag with its own one-cycle clear input. The bit-rate tick comes from outside the block. While the host has not yet cleared receive-done, a new frame does not overwrite the held byte.

Top module: `uart_addr_rx`

## Requirements
- R1: While reset is asserted and after it is released, `ri_o` and `fe_o` are 0 and `rx_data_o` and `rx_bit9_o` are 0.
- R2: A frame is a low start bit, then data bits sent least significant bit first, then a high stop bit. Each bit lasts 16 ticks. Its value is the majority of the line samples taken at ticks 7, 8 and 9 of the bit, where tick 0 is the first tick that sees the start edge. A single inverted sample does not change the received value.
- R3: With `nine_bit_i`=1 the frame carries a ninth data bit after D7, and that bit is delivered on `rx_bit9_o`. With `nine_bit_i`=0, `rx_bit9_o` is loaded with the stop-bit value when the frame completes at its stop bit, and with 0 when it completes at D7.
- R4: If the vote over the start bit is high, the start is treated as a glitch. No frame is delivered, and the receiver accepts the next falling edge.
- R5: With `mp_en_i`=0, every frame that completes sets `ri_o`, whatever its ninth bit or its byte value.
- R6: With `mp_en_i`=1 and `nine_bit_i`=1, a frame whose ninth bit is 0 never sets `ri_o`.
- R7: With `mp_en_i`=1, a frame sets `ri_o` only if its byte matches one of two patterns. It matches the own address if it equals `own_addr_i` on every bit where `addr_mask_i` is 1. It matches the broadcast pattern if it is 1 on every bit where `own_addr_i | addr_mask_i` is 1.
- R8: With `mp_en_i`=1 and `nine_bit_i`=0, the stop bit takes the place of the ninth bit. `ri_o` is set only if the address matches and the stop bit is high.
- R9: The frame completes, and `ri_o` may rise, on the tick after sample 9 of the last data bit. It completes on the same tick of the stop bit instead when `fe_en_i`=1 or when 8-bit multiprocessor operation is selected. A frame that completes at its stop bit with the stop bit low is not delivered.
- R10: With `fe_en_i`=1, a stop bit voted low sets `fe_o`. `fe_o` stays set through later valid frames and falls only on `clr_fe_i`. A set in the same cycle as `clr_fe_i` wins. With `fe_en_i`=0, `fe_o` never rises.
- R11: While `ri_o` is pending, a completing frame is dropped and `rx_data_o` and `rx_bit9_o` hold. If `clr_ri_i` arrives in the completion cycle, the new frame is accepted and `ri_o` stays 1.
- R12: `clr_ri_i` clears `ri_o` on the next edge unless a frame is accepted in that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd_i | input | 1 | Serial line, idle high |
| baud_tick_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| nine_bit_i | input | 1 | 1 selects 9 data bits, 0 selects 8 |
| mp_en_i | input | 1 | Multiprocessor address filtering enable |
| fe_en_i | input | 1 | Framing-error check enable; moves completion to the stop bit |
| own_addr_i | input | 8 | Node address register |
| addr_mask_i | input | 8 | Address mask; a 0 bit is don't-care in the own compare |
| clr_ri_i | input | 1 | Clear receive-done |
| clr_fe_i | input | 1 | Clear framing error |
| rx_data_o | output | 8 | Last accepted data byte |
| rx_bit9_o | output | 1 | Ninth bit, or stop bit, of the last accepted frame |
| ri_o | output | 1 | Receive-done flag |
| fe_o | output | 1 | Sticky framing-error flag |

## Verification
Two events can fall in the same cycle: the host clearing receive-done, and a new frame completing. The bench provokes this by pulsing `clr_ri_i` on exactly the tick after sample 9 of D7, while an earlier byte is still pending. It expects the new byte to be loaded and `ri_o` to stay high. A reference model that advances per tick is compared with all four outputs on every clock. Any cycle in which the flag drops or the old byte survives is therefore reported at that cycle.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;

  localparam int unsigned VOTE_TAPS = 3;

endpackage

// File: rtl/uart_rx_sampler.sv
module uart_rx_sampler #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rxd_i,
  input  logic tick_i,
  output logic line_o,
  output logic vote_o,
  output logic prev_o
);
  import uart_rx_pkg::*;

  logic [SYNC_STAGES-1:0]     sync_q;
  logic [VOTE_TAPS-1:0]       win_q;
  logic [VOTE_TAPS-1:0]       win_d;

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    logic stage_d;
    if (g == 0) begin : g_first
      assign stage_d = rxd_i;
    end else begin : g_rest
      assign stage_d = sync_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b1;
      else        sync_q[g] <= stage_d;
    end
  end

  assign line_o = sync_q[SYNC_STAGES-1];

  always_comb begin
    win_d = win_q;
    if (tick_i) win_d = {win_q[VOTE_TAPS-2:0], line_o};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) win_q <= '1;
    else        win_q <= win_d;
  end

  assign vote_o = (win_q[0] & win_q[1]) | (win_q[0] & win_q[2]) | (win_q[1] & win_q[2]);
  assign prev_o = win_q[0];

endmodule

// File: rtl/uart_rx_framer.sv
module uart_rx_framer #(
  parameter int unsigned OSR    = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned MID    = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              line_i,
  input  logic              prev_i,
  input  logic              vote_i,
  input  logic              nine_bit_i,
  output logic              data_end_o,
  output logic              stop_end_o,
  output logic [DATA_W:0]   word_o
);
  import uart_rx_pkg::*;

  localparam int unsigned CNT_W   = $clog2(OSR);
  localparam int unsigned WORD_W  = DATA_W + 1;
  localparam int unsigned IDX_W   = $clog2(WORD_W + 1);
  localparam logic [CNT_W-1:0] DEC_CNT  = CNT_W'(MID + 2);
  localparam logic [CNT_W-1:0] WRAP_CNT = CNT_W'(OSR - 1);

  rx_state_e          st_q, st_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [IDX_W-1:0]   idx_q, idx_d;
  logic [WORD_W-1:0]  word_q, word_d;
  logic [IDX_W-1:0]   last_idx;

  assign last_idx = nine_bit_i ? IDX_W'(DATA_W) : IDX_W'(DATA_W - 1);

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    word_d     = word_q;
    data_end_o = 1'b0;
    stop_end_o = 1'b0;
    if (st_q == RX_IDLE) begin
      if (tick_i && !line_i && prev_i) begin
        st_d  = RX_START;
        cnt_d = CNT_W'(1);
      end
    end else if (tick_i) begin
      cnt_d = (cnt_q == WRAP_CNT) ? '0 : cnt_q + CNT_W'(1);
      if (cnt_q == DEC_CNT) begin
        case (st_q)
          RX_START: begin
            if (vote_i) begin
              st_d  = RX_IDLE;
              cnt_d = '0;
            end
          end
          RX_DATA: begin
            word_d[idx_q] = vote_i;
            if (idx_q == last_idx) data_end_o = 1'b1;
          end
          default: begin
            stop_end_o = 1'b1;
            st_d       = RX_IDLE;
            cnt_d      = '0;
          end
        endcase
      end
      if (cnt_q == WRAP_CNT) begin
        if (st_q == RX_START) begin
          st_d  = RX_DATA;
          idx_d = '0;
        end else if (st_q == RX_DATA) begin
          if (idx_q == last_idx) st_d = RX_STOP;
          else                   idx_d = idx_q + IDX_W'(1);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      idx_q  <= '0;
      word_q <= '0;
    end else if (tick_i) begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      idx_q  <= idx_d;
      word_q <= word_d;
    end
  end

  assign word_o = word_d;

endmodule

// File: rtl/uart_rx_addr_match.sv
module uart_rx_addr_match #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  output logic              hit_o
);
  logic own_hit;
  logic bcast_hit;

  assign own_hit   = ((byte_i ^ addr_i) & mask_i) == '0;
  assign bcast_hit = ((~byte_i) & (addr_i | mask_i)) == '0;
  assign hit_o     = own_hit | bcast_hit;

endmodule

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OSR         = 16,
  parameter int unsigned MID         = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rxd_i,
  input  logic              baud_tick_i,
  input  logic              nine_bit_i,
  input  logic              mp_en_i,
  input  logic              fe_en_i,
  input  logic [DATA_W-1:0] own_addr_i,
  input  logic [DATA_W-1:0] addr_mask_i,
  input  logic              clr_ri_i,
  input  logic              clr_fe_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_bit9_o,
  output logic              ri_o,
  output logic              fe_o
);

  logic            line_s, vote_s, prev_s;
  logic            data_end, stop_end;
  logic [DATA_W:0] word;
  logic            addr_hit;

  uart_rx_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
    .clk    (clk),
    .rst_n  (rst_n),
    .rxd_i  (rxd_i),
    .tick_i (baud_tick_i),
    .line_o (line_s),
    .vote_o (vote_s),
    .prev_o (prev_s)
  );

  uart_rx_framer #(.OSR(OSR), .DATA_W(DATA_W), .MID(MID)) u_framer (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (baud_tick_i),
    .line_i     (line_s),
    .prev_i     (prev_s),
    .vote_i     (vote_s),
    .nine_bit_i (nine_bit_i),
    .data_end_o (data_end),
    .stop_end_o (stop_end),
    .word_o     (word)
  );

  uart_rx_addr_match #(.DATA_W(DATA_W)) u_match (
    .byte_i (word[DATA_W-1:0]),
    .addr_i (own_addr_i),
    .mask_i (addr_mask_i),
    .hit_o  (addr_hit)
  );

  logic              at_stop, complete, ninth, stop_ok, filt_ok, slot_busy, accept, fe_set;
  logic              ri_q, ri_d, fe_q, fe_d, bit9_q;
  logic [DATA_W-1:0] data_q;

  always_comb begin
    at_stop   = fe_en_i | (mp_en_i & ~nine_bit_i);
    complete  = at_stop ? stop_end : data_end;
    ninth     = nine_bit_i ? word[DATA_W] : (at_stop & vote_s);
    stop_ok   = ~at_stop | vote_s;
    filt_ok   = ~mp_en_i | (ninth & addr_hit);
    slot_busy = ri_q & ~clr_ri_i;
    accept    = complete & stop_ok & filt_ok & ~slot_busy;
    fe_set    = stop_end & fe_en_i & ~vote_s;
    ri_d      = accept ? 1'b1 : (clr_ri_i ? 1'b0 : ri_q);
    fe_d      = fe_set ? 1'b1 : (clr_fe_i ? 1'b0 : fe_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ri_q <= 1'b0;
      fe_q <= 1'b0;
    end else begin
      ri_q <= ri_d;
      fe_q <= fe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bit9_q <= 1'b0;
    end else if (accept) begin
      data_q <= word[DATA_W-1:0];
      bit9_q <= ninth;
    end
  end

  assign rx_data_o = data_q;
  assign rx_bit9_o = bit9_q;
  assign ri_o      = ri_q;
  assign fe_o      = fe_q;

endmodule

// File: rtl/uart_addr_rx_chk.sv
module uart_addr_rx_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mp_en_i,
  input logic              fe_en_i,
  input logic [DATA_W-1:0] own_addr_i,
  input logic [DATA_W-1:0] addr_mask_i,
  input logic              clr_ri_i,
  input logic              clr_fe_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              rx_bit9_o,
  input logic              ri_o,
  input logic              fe_o,
  input logic              accept_i
);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_clear_r1: assert (!ri_o && !fe_o && rx_data_o == '0 && !rx_bit9_o);
    end
  end

  p_fe_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fe_o && !clr_fe_i |=> fe_o);

  p_fe_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_o) |-> $past(fe_en_i));

  p_hold_pending_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ri_o && !clr_ri_i |=> $stable(rx_data_o) && $stable(rx_bit9_o) && ri_o);

  p_load_only_accept_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_i |=> $stable(rx_data_o));

  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    clr_ri_i && !accept_i |=> !ri_o);

  p_mp_ninth_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_o) && mp_en_i |-> rx_bit9_o);

  p_addr_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ri_o) && mp_en_i |->
      ((((rx_data_o ^ own_addr_i) & addr_mask_i) == '0) ||
       (((~rx_data_o) & (own_addr_i | addr_mask_i)) == '0)));

endmodule

bind uart_addr_rx uart_addr_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mp_en_i     (mp_en_i),
  .fe_en_i     (fe_en_i),
  .own_addr_i  (own_addr_i),
  .addr_mask_i (addr_mask_i),
  .clr_ri_i    (clr_ri_i),
  .clr_fe_i    (clr_fe_i),
  .rx_data_o   (rx_data_o),
  .rx_bit9_o   (rx_bit9_o),
  .ri_o        (ri_o),
  .fe_o        (fe_o),
  .accept_i    (accept)
);

// File: tb/uart_addr_rx_bench.sv
module uart_addr_rx_bench;

  logic       clk;
  logic       rst_n;
  logic       rxd;
  logic       tick;
  logic       nine;
  logic       mp_en;
  logic       fe_en;
  logic [7:0] own;
  logic [7:0] mask;
  logic       clr_ri;
  logic       clr_fe;
  logic [7:0] rx_data;
  logic       rx_bit9;
  logic       ri;
  logic       fe;

  int    n_chk;
  int    n_err;
  bit    running;
  bit    finished;
  string cur_req;

  uart_addr_rx u_uart_addr_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .rxd_i       (rxd),
    .baud_tick_i (tick),
    .nine_bit_i  (nine),
    .mp_en_i     (mp_en),
    .fe_en_i     (fe_en),
    .own_addr_i  (own),
    .addr_mask_i (mask),
    .clr_ri_i    (clr_ri),
    .clr_fe_i    (clr_fe),
    .rx_data_o   (rx_data),
    .rx_bit9_o   (rx_bit9),
    .ri_o        (ri),
    .fe_o        (fe)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // reference model, advanced per tick
  logic       m_ri, m_fe, m_b9, m_busy, m_last;
  logic [7:0] m_data;
  logic [8:0] m_word;
  logic       samp [0:199];
  int         m_t;

  function automatic bit addr_ok(input logic [7:0] d);
    bit o, b;
    o = 1'b1;
    b = 1'b1;
    for (int i = 0; i < 8; i++) begin
      if (mask[i] && d[i] != own[i]) o = 1'b0;
      if ((own[i] || mask[i]) && !d[i]) b = 1'b0;
    end
    return o || b;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ri = 0; m_fe = 0; m_b9 = 0; m_data = '0; m_word = '0;
      m_busy = 0; m_last = 1; m_t = 0;
    end else begin
      bit dend, send, stopmode, fin, okf;
      logic v, b9;
      int b, lastb;
      dend = 0; send = 0; v = 1'b1;
      lastb = nine ? 9 : 8;
      if (tick) begin
        if (!m_busy) begin
          if (rxd == 1'b0 && m_last == 1'b1) begin
            m_busy = 1; m_t = 0; samp[0] = 1'b0;
          end
        end else begin
          m_t = m_t + 1;
          samp[m_t] = rxd;
          if (m_t % 16 == 10) begin
            b = m_t / 16;
            v = (samp[m_t-3] && samp[m_t-2]) || (samp[m_t-3] && samp[m_t-1]) ||
                (samp[m_t-2] && samp[m_t-1]);
            if (b == 0) begin
              if (v) m_busy = 0;
            end else if (b <= lastb) begin
              m_word[b-1] = v;
              if (b == lastb) dend = 1;
            end else begin
              send = 1; m_busy = 0;
            end
          end
        end
        m_last = rxd;
      end
      stopmode = fe_en || (mp_en && !nine);
      fin = stopmode ? send : dend;
      b9  = nine ? m_word[8] : (stopmode ? v : 1'b0);
      okf = fin && (!stopmode || v) && (!mp_en || (b9 && addr_ok(m_word[7:0]))) &&
            !(m_ri && !clr_ri);
      if (send && fe_en && !v) m_fe = 1;
      else if (clr_fe)         m_fe = 0;
      if (okf) begin
        m_ri = 1; m_data = m_word[7:0]; m_b9 = b9;
      end else if (clr_ri) begin
        m_ri = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (running) begin
      n_chk++;
      if (ri !== m_ri || fe !== m_fe || rx_data !== m_data || rx_bit9 !== m_b9) begin
        n_err++;
        $display("FAIL %s cycle compare: actual ri=%b fe=%b data=%h b9=%b expected ri=%b fe=%b data=%h b9=%b",
                 cur_req, ri, fe, rx_data, rx_bit9, m_ri, m_fe, m_data, m_b9);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic one_tick(input logic v, input logic c);
    rxd = v; tick = 0; clr_ri = 0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    tick = 1; clr_ri = c;
    @(negedge clk);
    tick = 0; clr_ri = 0;
  endtask

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) one_tick(1'b1, 1'b0);
  endtask

  // clr_t: tick index for clr_ri; flip_t: tick index whose line value is inverted;
  // chk_b: bit index after which ri is compared with exp_mid
  task automatic send_frame(input logic [8:0] w, input logic stopv, input int clr_t,
                            input int flip_t, input int chk_b, input logic exp_mid,
                            input string req);
    int nb, db;
    logic v;
    db = nine ? 9 : 8;
    nb = db + 2;
    for (int t = 0; t < 16 * nb; t++) begin
      int b;
      b = t / 16;
      if (b == 0)        v = 1'b0;
      else if (b <= db)  v = w[b-1];
      else               v = stopv;
      if (t == flip_t) v = ~v;
      one_tick(v, t == clr_t);
      if (t % 16 == 15 && b == chk_b) chk({req, " mid-frame ri"}, {7'd0, ri}, {7'd0, exp_mid});
    end
    idle_ticks(20);
  endtask

  task automatic pulse_clr_ri;
    @(negedge clk); clr_ri = 1; @(negedge clk); clr_ri = 0;
  endtask

  task automatic pulse_clr_fe;
    @(negedge clk); clr_fe = 1; @(negedge clk); clr_fe = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_err = 0; running = 0; finished = 0;
    rst_n = 0; rxd = 1; tick = 0; clr_ri = 0; clr_fe = 0;
    nine = 0; mp_en = 0; fe_en = 0; own = 8'h5A; mask = 8'hF0;
    cur_req = "R1";
    repeat (4) @(negedge clk);
    chk("R1 ri in reset", {7'd0, ri}, 8'h00);
    chk("R1 fe in reset", {7'd0, fe}, 8'h00);
    rst_n = 1;
    running = 1;
    @(negedge clk);
    chk("R1 data after reset", rx_data, 8'h00);
    chk("R1 bit9 after reset", {7'd0, rx_bit9}, 8'h00);
    idle_ticks(4);

    // 8-bit, no filtering, completes at D7 (bit 8)
    cur_req = "R2";
    send_frame(9'h0A5, 1'b1, -1, -1, 8, 1'b1, "R9 early 8-bit");
    chk("R2 data", rx_data, 8'hA5);
    chk("R3 bit9 early 8-bit", {7'd0, rx_bit9}, 8'h00);
    cur_req = "R12";
    pulse_clr_ri;
    chk("R12 ri cleared", {7'd0, ri}, 8'h00);

    // voting: sample 8 of D0 inverted
    cur_req = "R2";
    send_frame(9'h00F, 1'b1, -1, 24, -1, 1'b0, "R2");
    chk("R2 vote data", rx_data, 8'h0F);
    pulse_clr_ri;

    // pending slot
    cur_req = "R11";
    send_frame(9'h03C, 1'b1, -1, -1, -1, 1'b0, "R11");
    send_frame(9'h077, 1'b1, -1, -1, -1, 1'b0, "R11");
    chk("R11 data held while pending", rx_data, 8'h3C);
    chk("R11 ri still set", {7'd0, ri}, 8'h01);
    pulse_clr_ri;

    // 9-bit, no filtering
    nine = 1;
    cur_req = "R3";
    send_frame(9'h1C3, 1'b1, -1, -1, 9, 1'b1, "R9 early 9-bit");
    chk("R3 data", rx_data, 8'hC3);
    chk("R3 bit9", {7'd0, rx_bit9}, 8'h01);
    pulse_clr_ri;
    cur_req = "R5";
    send_frame(9'h042, 1'b1, -1, -1, -1, 1'b0, "R5");
    chk("R5 data frame accepted", {7'd0, ri}, 8'h01);
    chk("R5 bit9 zero", {7'd0, rx_bit9}, 8'h00);
    pulse_clr_ri;

    // 9-bit filtering
    mp_en = 1;
    cur_req = "R6";
    send_frame(9'h05A, 1'b1, -1, -1, -1, 1'b0, "R6");
    chk("R6 data frame dropped", {7'd0, ri}, 8'h00);
    cur_req = "R7";
    send_frame(9'h133, 1'b1, -1, -1, -1, 1'b0, "R7");
    chk("R7 foreign address dropped", {7'd0, ri}, 8'h00);
    send_frame(9'h153, 1'b1, -1, -1, -1, 1'b0, "R7");
    chk("R7 own address (masked) accepted", rx_data, 8'h53);
    chk("R7 own ri", {7'd0, ri}, 8'h01);
    pulse_clr_ri;
    send_frame(9'h1FB, 1'b1, -1, -1, -1, 1'b0, "R7");
    chk("R7 broadcast accepted", rx_data, 8'hFB);
    pulse_clr_ri;

    // 8-bit filtering: stop as ninth bit
    nine = 0;
    cur_req = "R8";
    send_frame(9'h053, 1'b1, -1, -1, 8, 1'b0, "R9 waits for stop");
    chk("R8 ri on valid stop", {7'd0, ri}, 8'h01);
    chk("R8 bit9 is stop", {7'd0, rx_bit9}, 8'h01);
    pulse_clr_ri;
    send_frame(9'h053, 1'b0, -1, -1, -1, 1'b0, "R8");
    chk("R8 low stop dropped", {7'd0, ri}, 8'h00);
    chk("R10 no fe while disabled", {7'd0, fe}, 8'h00);
    send_frame(9'h033, 1'b1, -1, -1, -1, 1'b0, "R8");
    chk("R8 mismatch dropped", {7'd0, ri}, 8'h00);

    // framing error
    mp_en = 0; fe_en = 1;
    cur_req = "R10";
    send_frame(9'h011, 1'b0, -1, -1, -1, 1'b0, "R10");
    chk("R10 fe set", {7'd0, fe}, 8'h01);
    chk("R9 low stop not delivered", {7'd0, ri}, 8'h00);
    send_frame(9'h022, 1'b1, -1, -1, -1, 1'b0, "R10");
    chk("R10 fe sticky", {7'd0, fe}, 8'h01);
    chk("R10 good frame delivered", rx_data, 8'h22);
    pulse_clr_ri;
    pulse_clr_fe;
    chk("R10 fe cleared", {7'd0, fe}, 8'h00);

    // completion moved to stop in 9-bit mode
    nine = 1;
    cur_req = "R9";
    send_frame(9'h1AA, 1'b1, -1, -1, 9, 1'b0, "R9 late 9-bit");
    chk("R9 ri after stop", {7'd0, ri}, 8'h01);
    pulse_clr_ri;

    // start glitch
    nine = 0; fe_en = 0;
    cur_req = "R4";
    for (int i = 0; i < 4; i++) one_tick(1'b0, 1'b0);
    idle_ticks(40);
    chk("R4 glitch gives no frame", {7'd0, ri}, 8'h00);
    send_frame(9'h066, 1'b1, -1, -1, -1, 1'b0, "R4");
    chk("R4 receiver recovers", rx_data, 8'h66);

    // clear in the completion cycle while pending: 16*8+10
    cur_req = "R11";
    send_frame(9'h099, 1'b1, 138, -1, -1, 1'b0, "R11");
    chk("R11 same-cycle clear accepts new byte", rx_data, 8'h99);
    chk("R11 ri stays set", {7'd0, ri}, 8'h01);
    pulse_clr_ri;

    running = 0;
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule